// File: doc/BRIEF.md
# Packed Quadword Register Unpacker

This block converts one 128-bit packed quadword into a single 64-bit register write for a graphics register file. A sequencer upstream hands it a quadword together with a 4-bit register descriptor; the descriptor says which register the quadword feeds and where that register's fields sit inside the quadword's four 32-bit lanes. The block gathers those scattered fields into a compact 64-bit value and issues one write strobe with an 8-bit register address one clock later.

The block keeps one piece of state: a 32-bit Q value. A texture-coordinate write loads Q from the quadword, and every later colour write carries the stored Q in its upper half. For the two vertex formats, bit 111 of the quadword picks between the drawing ("kick") register and an alternate register that does not kick. A no-op descriptor produces nothing, and the reserved descriptor raises a one-cycle error pulse in place of a write. Sequencing of tags, loops and paths is the job of the surrounding logic.

Top module: `qw_unpacker`

## Requirements
- R1: After reset `wrValid` and `descError` are low and the stored Q is 0x3F800000 (single-precision 1.0).
- R2: A beat with `inValid` high and `inDesc` not 0xF/0xB gives exactly one cycle of `wrValid` on the clock edge after the one that samples it; a cycle with `inValid` low gives neither `wrValid` nor `descError` on the next edge.
- R3: Descriptor 0x0 writes address 0x00 with data = quadword bits 10:0, zero-extended.
- R4: Descriptor 0x1 writes address 0x01 with data[7:0]=bits 7:0, data[15:8]=bits 39:32, data[23:16]=bits 71:64, data[31:24]=bits 103:96 and data[63:32] = the stored Q.
- R5: Descriptor 0x2 writes address 0x02 with data[31:0]=bits 31:0 and data[63:32]=bits 63:32, and loads Q from bits 95:64; no other descriptor changes Q.
- R6: Descriptor 0x3 writes address 0x03 with data[13:0]=bits 13:0, data[29:16]=bits 45:32, all other bits zero.
- R7: Descriptor 0x4 writes data[15:0]=bits 15:0, data[31:16]=bits 47:32, data[55:32]=bits 91:68, data[63:56]=bits 107:100, to address 0x04 when bit 111 is 0 and 0x0C when it is 1.
- R8: Descriptor 0x5 writes data[15:0]=bits 15:0, data[31:16]=bits 47:32, data[63:32]=bits 95:64, to address 0x05 when bit 111 is 0 and 0x0D when it is 1.
- R9: Descriptor 0xA writes address 0x0A with data[63:56]=bits 107:100 and all other bits zero.
- R10: Descriptor 0xE writes data = bits 63:0 to the address held in bits 71:64.
- R11: Descriptors 0x6, 0x7, 0x8, 0x9, 0xC and 0xD write bits 63:0 unchanged to the address equal to the descriptor value; bit 111 has no effect on them.
- R12: Descriptor 0xF produces no write and no error; descriptor 0xB produces no write and a one-cycle `descError` pulse on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Quadword and descriptor are valid this cycle |
| inDesc | input | 4 | Register descriptor for the quadword |
| inQword | input | 128 | Packed quadword |
| wrValid | output | 1 | Single-cycle register write strobe |
| wrAddr | output | 8 | Register address of the write |
| wrData | output | 64 | Register data of the write |
| descError | output | 1 | One-cycle pulse for a reserved descriptor |

## Verification
The bench aims at Q carry-over: a colour write before any texture write must show 1.0, and one after a texture write must show that write's bits 95:64 even when no-op, reserved and raw writes sit between them; a design that loaded Q from the wrong lane or on the wrong descriptor would put a stale or foreign value in the colour word. It sets bit 111 on both vertex formats and on the raw formats, catching a design that ignores the select or leaks it into addresses that must not move. Quadwords with every lane filled by pseudo-random data expose any field taken from a neighbouring lane or left unmasked, and the no-op and reserved beats check that a design neither emits a stray strobe nor misses the error pulse.

// File: rtl/qw_unpacker_pkg.sv
package qw_unpacker_pkg;

  // Descriptor codes the decoder keys on
  localparam logic [3:0] DESC_PRIM  = 4'h0;
  localparam logic [3:0] DESC_COLOR = 4'h1;
  localparam logic [3:0] DESC_TEXST = 4'h2;
  localparam logic [3:0] DESC_UV    = 4'h3;
  localparam logic [3:0] DESC_VTXF  = 4'h4;
  localparam logic [3:0] DESC_VTX   = 4'h5;
  localparam logic [3:0] DESC_FOG   = 4'hA;
  localparam logic [3:0] DESC_RSVD  = 4'hB;
  localparam logic [3:0] DESC_ADDAT = 4'hE;
  localparam logic [3:0] DESC_NOP   = 4'hF;

  typedef enum logic [3:0] {
    FMT_PRIM,
    FMT_COLOR,
    FMT_TEXST,
    FMT_UV,
    FMT_VTXF,
    FMT_VTX,
    FMT_FOG,
    FMT_ADDAT,
    FMT_RAW
  } pack_fmt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      wrEn;
    logic      qLoad;
    logic      altReg;
    pack_fmt_e fmt;
  } unpack_ctl_t;

endpackage

// File: rtl/qw_unpack_ctrl.sv
module qw_unpack_ctrl
  import qw_unpacker_pkg::*;
#(
  parameter int DESC_W = 4,
  parameter int ALT_BIT = 111,
  parameter int QW_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DESC_W-1:0] inDesc,
  input  logic [QW_W-1:0]   inQword,
  output unpack_ctl_t       ctl,
  output logic              descError
);

  logic altSel;
  assign altSel = inQword[ALT_BIT];

  always_comb begin
    ctl = '{wrEn: 1'b0, qLoad: 1'b0, altReg: 1'b0, fmt: FMT_RAW};
    if (inValid) begin
      ctl.wrEn = 1'b1;
      unique case (inDesc)
        DESC_PRIM:  ctl.fmt = FMT_PRIM;
        DESC_COLOR: ctl.fmt = FMT_COLOR;
        DESC_TEXST: begin
          ctl.fmt   = FMT_TEXST;
          ctl.qLoad = 1'b1;
        end
        DESC_UV:    ctl.fmt = FMT_UV;
        DESC_VTXF: begin
          ctl.fmt    = FMT_VTXF;
          ctl.altReg = altSel;
        end
        DESC_VTX: begin
          ctl.fmt    = FMT_VTX;
          ctl.altReg = altSel;
        end
        DESC_FOG:   ctl.fmt = FMT_FOG;
        DESC_ADDAT: ctl.fmt = FMT_ADDAT;
        DESC_RSVD, DESC_NOP: ctl.wrEn = 1'b0;
        default:    ctl.fmt = FMT_RAW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) descError <= 1'b0;
    else       descError <= inValid && (inDesc == DESC_RSVD);
  end

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    descError |-> $past(inValid) && ($past(inDesc) == DESC_RSVD));

  // R5
  qload_desc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.qLoad |-> inValid && (inDesc == DESC_TEXST));

endmodule

// File: rtl/qw_unpack_dp.sv
module qw_unpack_dp
  import qw_unpacker_pkg::*;
#(
  parameter int QW_W = 128,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  parameter int DESC_W = 4,
  parameter int Q_W = 32,
  parameter logic [31:0] Q_RESET = 32'h3F80_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  unpack_ctl_t       ctl,
  input  logic [DESC_W-1:0] inDesc,
  input  logic [QW_W-1:0]   inQword,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int LANE_W   = 32;
  localparam int LANES    = QW_W / LANE_W;
  localparam int CH_W     = 8;
  localparam int ALT_OFS  = 8;
  localparam int QSRC_LO  = 2 * LANE_W;

  logic [Q_W-1:0] qReg;
  logic [LANES*CH_W-1:0] colorPack;
  logic [DATA_W-1:0] nextData;
  logic [ADDR_W-1:0] nextAddr;

  // One colour channel from the low byte of each lane
  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign colorPack[i*CH_W +: CH_W] = inQword[i*LANE_W +: CH_W];
  end

  always_comb begin
    nextData = '0;
    nextAddr = ADDR_W'(inDesc);
    unique case (ctl.fmt)
      FMT_PRIM:  nextData[10:0] = inQword[10:0];
      FMT_COLOR: nextData = {qReg, colorPack};
      FMT_TEXST: nextData = inQword[63:0];
      FMT_UV: begin
        nextData[13:0]  = inQword[13:0];
        nextData[29:16] = inQword[45:32];
      end
      FMT_VTXF: begin
        nextData[15:0]  = inQword[15:0];
        nextData[31:16] = inQword[47:32];
        nextData[55:32] = inQword[91:68];
        nextData[63:56] = inQword[107:100];
      end
      FMT_VTX: begin
        nextData[15:0]  = inQword[15:0];
        nextData[31:16] = inQword[47:32];
        nextData[63:32] = inQword[95:64];
      end
      FMT_FOG:   nextData[63:56] = inQword[107:100];
      FMT_ADDAT: begin
        nextData = inQword[63:0];
        nextAddr = inQword[71:64];
      end
      default:   nextData = inQword[63:0];
    endcase
    if (ctl.altReg) nextAddr = nextAddr | ADDR_W'(ALT_OFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qReg    <= Q_RESET;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= ctl.wrEn;
      if (ctl.wrEn) begin
        wrAddr <= nextAddr;
        wrData <= nextData;
      end
      if (ctl.qLoad) qReg <= inQword[QSRC_LO +: Q_W];
    end
  end

  // R5
  q_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.qLoad) |-> $stable(qReg));

  // R4
  color_q_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && $past(ctl.wrEn) && ($past(ctl.fmt) == FMT_COLOR))
      |-> (wrData[63:32] == $past(qReg)));

endmodule

// File: rtl/qw_unpacker.sv
module qw_unpacker
  import qw_unpacker_pkg::*;
#(
  parameter int QW_W = 128,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  parameter int DESC_W = 4,
  parameter int ALT_BIT = 111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DESC_W-1:0] inDesc,
  input  logic [QW_W-1:0]   inQword,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              descError
);

  unpack_ctl_t ctl;

  qw_unpack_ctrl #(.DESC_W(DESC_W), .ALT_BIT(ALT_BIT), .QW_W(QW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDesc(inDesc),
    .inQword(inQword), .ctl(ctl), .descError(descError)
  );

  qw_unpack_dp #(.QW_W(QW_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .DESC_W(DESC_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inDesc(inDesc), .inQword(inQword),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  // R12
  wr_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && descError));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> (!wrValid && !descError));

  // R7
  alt_vtxf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && ($past(inDesc) == DESC_VTXF) && $past(inQword[ALT_BIT]))
      |-> (wrValid && (wrAddr == ADDR_W'(8'h0C))));

  // R12
  nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && ($past(inDesc) == DESC_NOP))
      |-> (!wrValid && !descError));

endmodule

// File: tb/tb_qw_unpacker.sv
module tb_qw_unpacker;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   inDesc = '0;
  logic [127:0] inQword = '0;
  logic         wrValid;
  logic [7:0]   wrAddr;
  logic [63:0]  wrData;
  logic         descError;

  int checks = 0;
  int errors = 0;
  logic [31:0] qModel = 32'h3F80_0000;
  logic [31:0] rngState = 32'h1234_5678;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 none, 1 write, 2 error
    logic [7:0]  addr;
    logic [63:0] data;
    string       req;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  qw_unpacker dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDesc(inDesc),
    .inQword(inQword), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .descError(descError)
  );

  function automatic logic [31:0] rnd();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >> 17);
    rngState = rngState ^ (rngState << 5);
    return rngState;
  endfunction

  function automatic string reqFor(logic [3:0] d);
    case (d)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2: return "R5";
      4'h3: return "R6";
      4'h4: return "R7";
      4'h5: return "R8";
      4'hA: return "R9";
      4'hE: return "R10";
      4'hB, 4'hF: return "R12";
      default: return "R11";
    endcase
  endfunction

  // Driver: one beat, pushes the expected outcome
  task automatic drive(input logic [3:0] d, input logic [127:0] q);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    inDesc  = d;
    inQword = q;
    e.kind = 1;
    e.addr = {4'h0, d};
    e.data = q[63:0];
    e.req  = reqFor(d);
    case (d)
      4'h0: e.data = {53'd0, q[10:0]};
      4'h1: e.data = {qModel, q[103:96], q[71:64], q[39:32], q[7:0]};
      4'h2: begin e.data = q[63:0]; qModel = q[95:64]; end
      4'h3: e.data = {34'd0, q[45:32], 2'd0, q[13:0]};
      4'h4: begin
        e.data = {q[107:100], q[91:68], q[47:32], q[15:0]};
        if (q[111]) e.addr = 8'h0C;
      end
      4'h5: begin
        e.data = {q[95:64], q[47:32], q[15:0]};
        if (q[111]) e.addr = 8'h0D;
      end
      4'hA: e.data = {q[107:100], 56'd0};
      4'hE: e.addr = q[71:64];
      4'hB: e.kind = 2;
      4'hF: e.kind = 0;
      default: ;
    endcase
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inQword = {rnd(), rnd(), rnd(), rnd()};
      inDesc  = rnd();
    end
  endtask

  function automatic logic [127:0] rq();
    return {rnd(), rnd(), rnd(), rnd()};
  endfunction

  // Monitor: one result per driven beat, nothing otherwise (R2)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN) begin
        if (expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          checks++;
          if (e.kind == 1) begin
            if (!(wrValid && !descError && wrAddr == e.addr && wrData == e.data)) begin
              errors++;
              $display("FAIL %s: got v=%0b err=%0b addr=%h data=%h, expected v=1 err=0 addr=%h data=%h",
                       e.req, wrValid, descError, wrAddr, wrData, e.addr, e.data);
            end
          end else if (e.kind == 2) begin
            if (wrValid || !descError) begin
              errors++;
              $display("FAIL %s: reserved got v=%0b err=%0b, expected v=0 err=1", e.req, wrValid, descError);
            end
          end else begin
            if (wrValid || descError) begin
              errors++;
              $display("FAIL %s: no-op got v=%0b err=%0b, expected v=0 err=0", e.req, wrValid, descError);
            end
          end
        end else if (!done) begin
          checks++;
          if (wrValid || descError) begin
            errors++;
            $display("FAIL R2: idle got v=%0b err=%0b, expected v=0 err=0", wrValid, descError);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] q;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (wrValid || descError) begin
      errors++;
      $display("FAIL R1: got v=%0b err=%0b, expected v=0 err=0", wrValid, descError);
    end
    rstN = 1'b1;
    idle(2);

    // R1/R4: colour before any texture write carries 1.0
    drive(4'h1, 128'h11223344_55667788_99AABBCC_DDEEFF01);
    drive(4'h0, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF);   // R3
    // R5: load Q, then non-texture beats must not disturb it
    drive(4'h2, 128'hAAAAAAAA_C0DEF00D_87654321_0FEDCBA9);
    drive(4'hF, rq());                                     // R12 no-op
    drive(4'hB, rq());                                     // R12 reserved
    drive(4'h6, {rq()} | (128'd1 << 111));                 // R11 with bit 111
    drive(4'h1, 128'h01020304_05060708_090A0B0C_0D0E0F10); // R4 uses new Q
    drive(4'h3, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF);   // R6 masking
    drive(4'h4, 128'h00000000_00000000_00000000_00000000 | (128'd1 << 111)); // R7 alt
    drive(4'h4, 128'hFFFF7FFF_FFFFFFFF_FFFFFFFF_FFFFFFFF);   // R7 kick, all ones
    drive(4'h5, rq() | (128'd1 << 111));                   // R8 alt
    drive(4'h5, rq() & ~(128'd1 << 111));                  // R8 kick
    drive(4'hA, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF);   // R9
    drive(4'hE, 128'h00000000_000000A5_12345678_9ABCDEF0); // R10
    drive(4'h7, rq()); drive(4'h8, rq()); drive(4'h9, rq()); // R11
    drive(4'hC, rq() | (128'd1 << 111)); drive(4'hD, rq() | (128'd1 << 111)); // R11
    idle(3);                                               // R2 idle, R13-style gap
    drive(4'h1, rq());                                     // R4 Q still held
    // Random mix over every descriptor, back to back
    for (int i = 0; i < 400; i++) begin
      q = rq();
      drive(rnd() % 16, q);
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    done = 1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule